// File: doc/BRIEF.md
# Challenge-Response Watchdog

This block supervises a processor by asking it questions. It holds an 8-bit challenge token that software reads from the block. For each token, software must return four 8-bit answers in order, using answer indices 0, 1, 2 and 3. Each answer is a fixed function of the token and its index. Each answer must also arrive inside its own timing window. The window restarts every time an answer is accepted or a round restarts.

Any answer that arrives early, is wrong, or does not arrive at all counts as an error. An error raises an error accumulator by one and sends the round back to index 0. A complete, correct round lowers the accumulator by one, never below zero, and moves the token to the next state of a linear feedback shift register. When the accumulator reaches its limit, the block drives its reset output for a fixed number of cycles. After that it clears the accumulator and starts the round again.

The control is a three-state machine:
- `ST_CLOSED`: the window is not yet open.
- `ST_OPEN`: answers are accepted.
- `ST_TRIP`: the reset output is driven.

The transitions are:
- CLOSED→OPEN when the timer reaches the opening count.
- CLOSED→CLOSED or CLOSED→TRIP on an early write.
- OPEN→CLOSED on a correct answer, on a wrong answer, or on a timeout.
- OPEN→TRIP on a wrong answer or a timeout that brings the accumulator to its limit.
- TRIP→CLOSED when the reset pulse ends.

Top module: `qa_watchdog`

## Requirements
- R1: After `rst_n` is released, `token` is 0xA7, `cur_idx` is 0, `err_cnt` is 0, and `win_open`, `err_flag` and `wdg_rst` are all 0.
- R2: The expected answer for index i is the token rotated left by i bits, XORed with a constant for that index: 0x3C for i=0, 0xA5 for i=1, 0x5A for i=2 and 0xC3 for i=3.
- R3: After an index becomes current, its timer starts at 0 and counts one per cycle. The window is closed for counts 0 to OPEN_T-1 and open for counts OPEN_T to CLOSE_T, and `win_open` shows which. A write while the window is closed is an error.
- R4: If no write arrives up to and including the cycle at count CLOSE_T, that is a timeout error. After a timeout, `cur_idx` returns to 0 and the timer restarts.
- R5: A write in the open window whose `ans_idx` equals `cur_idx` and whose data equals the expected answer is accepted. It moves to the next index and restarts the timer at 0 with the window closed.
- R6: A write in the open window with a wrong `ans_idx` or wrong data is an error, and `cur_idx` returns to 0.
- R7: Accepting the answer for index 3 completes the round and returns `cur_idx` to 0. It also decrements `err_cnt`, never below 0. It replaces the token with {token[6:0], token[7]^token[5]^token[4]^token[3]}, which is the polynomial x^8+x^6+x^5+x^4+1. At all other times the token holds its value.
- R8: Every error adds one to `err_cnt`, and `err_flag` is high for exactly the next cycle.
- R9: An error that brings `err_cnt` to ERR_LIMIT (4) drives `wdg_rst` high for RST_LEN (6) cycles. During those cycles writes are ignored. At the end, `err_cnt` is 0, `cur_idx` is 0 and a new window starts.
- R10: The token is never zero. An all-zero register state is reloaded with the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ans_wr | input | 1 | Answer write strobe, one cycle per answer |
| ans_idx | input | 2 | Index the written answer claims |
| ans_data | input | 8 | Answer value |
| token | output | 8 | Current challenge token |
| cur_idx | output | 2 | Index of the answer expected next |
| err_cnt | output | 3 | Error accumulator value |
| win_open | output | 1 | High while the current answer window is open |
| err_flag | output | 1 | One-cycle pulse after each error |
| wdg_rst | output | 1 | Watchdog reset output |

## Verification
The case where two functions meet in one cycle is the last cycle of the window, at count CLOSE_T. In that cycle an answer can be accepted or the timeout can fire. The bench writes answers after exactly CLOSE_T idle cycles, both in a directed case and at random. The correct result is an accepted answer with no error. One idle cycle more must instead give a timeout, with the accumulator raised by one. A cycle-level model built from the requirements judges every cycle, so an early or late slip of one cycle shows up on `win_open`, `err_cnt` and `cur_idx`.

// File: rtl/qa_wdg_pkg.sv
package qa_wdg_pkg;

    localparam int DATA_W = 8;
    localparam int N_ANS  = 4;
    localparam int IDX_W  = $clog2(N_ANS);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [1:0] {
        ST_CLOSED = 2'd0,
        ST_OPEN   = 2'd1,
        ST_TRIP   = 2'd2
    } wdg_state_t;

    // Per-index constant mixed into each answer.
    function automatic word_t index_key(idx_t i);
        word_t k;
        case (i)
            2'd0:    k = 8'h3C;
            2'd1:    k = 8'hA5;
            2'd2:    k = 8'h5A;
            default: k = 8'hC3;
        endcase
        return k;
    endfunction

    // Rotate left by the index, then mix with the index constant.
    function automatic word_t expected_answer(word_t tok, idx_t i);
        word_t r;
        r = tok;
        for (int n = 0; n < N_ANS; n++) begin
            if (n < int'(i)) begin
                r = {r[DATA_W-2:0], r[DATA_W-1]};
            end
        end
        return r ^ index_key(i);
    endfunction

endpackage

// File: rtl/qa_token_lfsr.sv
module qa_token_lfsr #(
    parameter int          W        = 8,
    parameter logic [W-1:0] SEED     = 8'hA7,
    parameter logic [W-1:0] TAP_MASK = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    output logic [W-1:0] state
);

    logic [W-1:0] state_q;
    logic         feedback;

    assign feedback = ^(state_q & TAP_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (state_q == '0) begin
            state_q <= SEED;
        end else if (advance) begin
            state_q <= {state_q[W-2:0], feedback};
        end
    end

    assign state = state_q;

endmodule

// File: rtl/qa_window_timer.sv
module qa_window_timer #(
    parameter int MAX_COUNT = 11,
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] count
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(MAX_COUNT)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/qa_answer_check.sv
module qa_answer_check
    import qa_wdg_pkg::*;
(
    input  word_t token,
    input  idx_t  cur_idx,
    input  idx_t  wr_idx,
    input  word_t wr_data,
    output logic  match
);

    word_t exp_tab [N_ANS];

    for (genvar g = 0; g < N_ANS; g++) begin : g_exp
        assign exp_tab[g] = expected_answer(token, idx_t'(g));
    end

    assign match = (wr_idx == cur_idx) && (wr_data == exp_tab[cur_idx]);

endmodule

// File: rtl/qa_err_accum.sv
module qa_err_accum #(
    parameter int LIMIT = 4,
    localparam int AW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          clr,
    output logic [AW-1:0] count,
    output logic          reach
);

    logic [AW-1:0] cnt_q;

    assign reach = inc && (cnt_q == AW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + AW'(1);
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - AW'(1);
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/qa_watchdog.sv
module qa_watchdog
    import qa_wdg_pkg::*;
#(
    parameter int    OPEN_T    = 4,
    parameter int    CLOSE_T   = 11,
    parameter int    ERR_LIMIT = 4,
    parameter int    RST_LEN   = 6,
    parameter word_t SEED      = 8'hA7,
    parameter word_t TAP_MASK  = 8'hB8,
    localparam int   ACC_W     = $clog2(ERR_LIMIT + 1),
    localparam int   TMR_MAX   = (CLOSE_T > RST_LEN) ? CLOSE_T : RST_LEN,
    localparam int   TMR_W     = $clog2(TMR_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ans_wr,
    input  logic [IDX_W-1:0] ans_idx,
    input  logic [DATA_W-1:0] ans_data,
    output logic [DATA_W-1:0] token,
    output logic [IDX_W-1:0] cur_idx,
    output logic [ACC_W-1:0] err_cnt,
    output logic             win_open,
    output logic             err_flag,
    output logic             wdg_rst
);

    wdg_state_t       state_q, state_d;
    logic [TMR_W-1:0] tmr_cnt;
    idx_t             idx_q;
    logic             flag_q;
    logic             match;
    logic             reach;
    logic             ev_good, ev_last, ev_err, trip_done;
    logic             at_open_edge, at_close_edge;

    // Submodules
    qa_token_lfsr #(
        .W        (DATA_W),
        .SEED     (SEED),
        .TAP_MASK (TAP_MASK)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (ev_last),
        .state   (token)
    );

    qa_window_timer #(
        .MAX_COUNT (TMR_MAX)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ev_err || ev_good || trip_done),
        .count   (tmr_cnt)
    );

    qa_answer_check u_check (
        .token   (token),
        .cur_idx (idx_q),
        .wr_idx  (ans_idx),
        .wr_data (ans_data),
        .match   (match)
    );

    qa_err_accum #(
        .LIMIT (ERR_LIMIT)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ev_err),
        .dec   (ev_last),
        .clr   (trip_done),
        .count (err_cnt),
        .reach (reach)
    );

    // Event decode
    assign at_open_edge  = (tmr_cnt == TMR_W'(OPEN_T - 1));
    assign at_close_edge = (tmr_cnt == TMR_W'(CLOSE_T));
    assign ev_good   = (state_q == ST_OPEN) && ans_wr && match;
    assign ev_last   = ev_good && (idx_q == idx_t'(N_ANS - 1));
    assign ev_err    = ((state_q == ST_CLOSED) && ans_wr)
                     || ((state_q == ST_OPEN) && ans_wr && !match)
                     || ((state_q == ST_OPEN) && !ans_wr && at_close_edge);
    assign trip_done = (state_q == ST_TRIP) && (tmr_cnt == TMR_W'(RST_LEN - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLOSED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLOSED: begin
                if (ev_err) begin
                    state_d = reach ? ST_TRIP : ST_CLOSED;
                end else if (at_open_edge) begin
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (ev_err) begin
                    state_d = reach ? ST_TRIP : ST_CLOSED;
                end else if (ev_good) begin
                    state_d = ST_CLOSED;
                end
            end
            ST_TRIP: begin
                if (trip_done) begin
                    state_d = ST_CLOSED;
                end
            end
            default: state_d = ST_CLOSED;
        endcase
    end

    // Answer index and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            flag_q <= ev_err;
            if (ev_err || trip_done || ev_last) begin
                idx_q <= '0;
            end else if (ev_good) begin
                idx_q <= idx_q + idx_t'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        win_open = (state_q == ST_OPEN);
        wdg_rst  = (state_q == ST_TRIP);
        err_flag = flag_q;
        cur_idx  = idx_q;
    end

endmodule

// File: rtl/qa_watchdog_chk.sv
module qa_watchdog_chk
    import qa_wdg_pkg::*;
#(
    parameter int ERR_LIMIT = 4,
    parameter int ACC_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ans_wr,
    input logic [IDX_W-1:0] ans_idx,
    input logic [DATA_W-1:0] token,
    input logic [IDX_W-1:0] cur_idx,
    input logic [ACC_W-1:0] err_cnt,
    input logic             win_open,
    input logic             err_flag,
    input logic             wdg_rst
);

    p_early_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ans_wr && !win_open && !wdg_rst) |=> (err_flag && cur_idx == '0));

    p_bad_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ans_wr && win_open && ans_idx != cur_idx) |=> (err_flag && cur_idx == '0));

    p_token_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ans_wr && win_open && cur_idx == IDX_W'(N_ANS - 1)) |=> $stable(token));

    p_err_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (err_cnt == $past(err_cnt) + ACC_W'(1)));

    p_trip_at_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdg_rst) |-> (err_cnt == ACC_W'(ERR_LIMIT)));

    p_trip_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_rst && ans_wr) |=> !err_flag);

    p_token_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        token != '0);

endmodule

bind qa_watchdog qa_watchdog_chk #(
    .ERR_LIMIT (ERR_LIMIT),
    .ACC_W     (ACC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ans_wr   (ans_wr),
    .ans_idx  (ans_idx),
    .token    (token),
    .cur_idx  (cur_idx),
    .err_cnt  (err_cnt),
    .win_open (win_open),
    .err_flag (err_flag),
    .wdg_rst  (wdg_rst)
);

// File: tb/qa_watchdog_tb_top.sv
module qa_watchdog_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int OPEN_T     = 4;
    localparam int CLOSE_T    = 11;
    localparam int ERR_LIMIT  = 4;
    localparam int RST_LEN    = 6;
    localparam int ACC_W      = $clog2(ERR_LIMIT + 1);
    localparam logic [7:0] SEED = 8'hA7;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ans_wr = 1'b0;
    logic [1:0]       ans_idx = '0;
    logic [7:0]       ans_data = '0;
    logic [7:0]       token;
    logic [1:0]       cur_idx;
    logic [ACC_W-1:0] err_cnt;
    logic             win_open, err_flag, wdg_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit live = 0;

    // Reference model state
    int         m_cnt, m_ph, m_idx, m_err;
    logic [7:0] m_tok;
    bit         m_flag;

    qa_watchdog #(
        .OPEN_T    (OPEN_T),
        .CLOSE_T   (CLOSE_T),
        .ERR_LIMIT (ERR_LIMIT),
        .RST_LEN   (RST_LEN)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ans_wr   (ans_wr),
        .ans_idx  (ans_idx),
        .ans_data (ans_data),
        .token    (token),
        .cur_idx  (cur_idx),
        .err_cnt  (err_cnt),
        .win_open (win_open),
        .err_flag (err_flag),
        .wdg_rst  (wdg_rst)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] exp_ans(logic [7:0] t, int i);
        logic [7:0] k;
        case (i)
            0:       k = 8'h3C;
            1:       k = 8'hA5;
            2:       k = 8'h5A;
            default: k = 8'hC3;
        endcase
        return ((t << i) | (t >> (8 - i))) ^ k;
    endfunction

    function automatic logic [7:0] lfsr_step(logic [7:0] t);
        return {t[6:0], t[7] ^ t[5] ^ t[4] ^ t[3]};
    endfunction

    task automatic chk(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Cycle model derived from the requirements
    always @(posedge clk) begin : model
        bit e, g;
        e = 0;
        g = 0;
        if (!rst_n) begin
            m_cnt = 0; m_ph = 0; m_idx = 0; m_err = 0; m_tok = SEED; m_flag = 0;
        end else begin
            case (m_ph)
                0: begin
                    if (ans_wr) e = 1;
                    else begin
                        if (m_cnt == OPEN_T - 1) m_ph = 1;
                        m_cnt++;
                    end
                end
                1: begin
                    if (ans_wr) begin
                        if (int'(ans_idx) == m_idx && ans_data == exp_ans(m_tok, m_idx)) g = 1;
                        else e = 1;
                    end else if (m_cnt == CLOSE_T) e = 1;
                    else m_cnt++;
                end
                default: begin
                    if (m_cnt == RST_LEN - 1) begin
                        m_ph = 0; m_cnt = 0; m_err = 0; m_idx = 0;
                    end else m_cnt++;
                end
            endcase
            m_flag = e;
            if (e) begin
                m_err++; m_idx = 0; m_cnt = 0;
                m_ph = (m_err >= ERR_LIMIT) ? 2 : 0;
            end
            if (g) begin
                m_cnt = 0; m_ph = 0;
                if (m_idx == 3) begin
                    m_idx = 0;
                    m_tok = lfsr_step(m_tok);
                    if (m_err > 0) m_err--;
                end else m_idx++;
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (live) begin
            chk(token == m_tok, "R7 token", token, m_tok);
            chk(token != 8'h00, "R10 token nonzero", token, 1);
            chk(int'(cur_idx) == m_idx, "R5 cur_idx", cur_idx, m_idx);
            chk(int'(err_cnt) == m_err, "R8 err_cnt", err_cnt, m_err);
            chk(err_flag == m_flag, "R8 err_flag", err_flag, m_flag);
            chk(win_open == (m_ph == 1), "R3 win_open", win_open, (m_ph == 1));
            chk(wdg_rst == (m_ph == 2), "R9 wdg_rst", wdg_rst, (m_ph == 2));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Idle for n cycles, then write one answer. mode: 0 good, 1 bad data, 2 bad index.
    task automatic put(int n, int mode);
        for (int c = 0; c < n; c++) @(negedge clk);
        ans_wr   = 1'b1;
        ans_idx  = 2'(m_idx);
        ans_data = exp_ans(m_tok, m_idx);
        if (mode == 1) ans_data = ans_data ^ 8'(1 + $urandom_range(0, 254));
        if (mode == 2) ans_idx = 2'(m_idx + 1 + $urandom_range(0, 2));
        @(negedge clk);
        ans_wr = 1'b0;
    endtask

    task automatic idle(int n);
        for (int c = 0; c < n; c++) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd715));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1;
        // R1: reset state
        chk(token == SEED && cur_idx == 0 && err_cnt == 0, "R1 reset regs",
            {token, 6'(cur_idx), 8'(err_cnt)}, {SEED, 14'h0});
        chk(!win_open && !err_flag && !wdg_rst, "R1 reset flags",
            {win_open, err_flag, wdg_rst}, 0);

        // R2: first correct answer accepted
        put(OPEN_T, 0);
        chk(cur_idx == 2'd1 && !err_flag, "R2 answer 0 accepted", cur_idx, 1);
        put(OPEN_T, 0); put(OPEN_T, 0); put(OPEN_T, 0);
        chk(token == lfsr_step(SEED), "R7 token after round", token, lfsr_step(SEED));

        // R3: answer in the last open cycle is accepted
        put(CLOSE_T, 0);
        chk(cur_idx == 2'd1 && err_cnt == 0, "R3 last window cycle", cur_idx, 1);
        // R3: one cycle early is an error
        put(OPEN_T - 1, 2'd0);
        chk(err_cnt == 1 && cur_idx == 0, "R3 early write", err_cnt, 1);
        // R4: timeout
        idle(CLOSE_T + 1);
        chk(err_cnt == 2 && err_flag && cur_idx == 0, "R4 timeout", err_cnt, 2);
        // R6: wrong index
        put(OPEN_T, 2);
        chk(err_cnt == 3 && cur_idx == 0, "R6 wrong index", err_cnt, 3);
        // R9: wrong data reaches the limit
        put(OPEN_T + 2, 1);
        chk(wdg_rst == 1'b1, "R9 trip asserted", wdg_rst, 1);
        put(0, 0);
        chk(!err_flag && wdg_rst, "R9 write ignored in trip", err_flag, 0);
        idle(RST_LEN - 1);
        chk(!wdg_rst && err_cnt == 0 && cur_idx == 0, "R9 trip ended", err_cnt, 0);

        // R7: decrement then saturation at zero
        put(0, 0);
        put(OPEN_T, 0); put(OPEN_T, 0); put(OPEN_T, 0); put(OPEN_T, 0);
        chk(err_cnt == 0, "R7 decrement", err_cnt, 0);
        put(OPEN_T, 0); put(OPEN_T, 0); put(OPEN_T, 0); put(OPEN_T, 0);
        chk(err_cnt == 0, "R7 saturate at zero", err_cnt, 0);

        // Constrained random mix
        for (int it = 0; it < 500; it++) begin
            int r;
            r = $urandom_range(0, 9);
            put($urandom_range(OPEN_T - 1, CLOSE_T + 2), (r < 7) ? 0 : ((r < 9) ? 1 : 2));
        end
        idle(RST_LEN + 2);

        live = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule